// File: doc/BRIEF.md
# Burst Column Address Generator

This block turns one column command into the stream of column addresses a synchronous DRAM burst needs. A controller presents a start column, a burst length code, an ordering choice, a read/write indication and a single-cycle start strobe. From the next cycle on, the block puts out one column address per cycle, with a valid flag and a last-beat flag, until the burst finishes, a stop strobe ends it, or a newer command takes its place.

Two orderings are supported. The wrapping order counts up inside a block aligned to the burst length. The exclusive-or order combines the start offset with the beat number. A page-length mode walks all columns of the row and keeps wrapping until it is stopped. A single-write option cuts write bursts to one beat and leaves reads at the programmed length. For the data path around the array, the block also delays a read-beat marker by the programmed CAS latency. It applies the data mask with zero latency on writes and with a two-cycle delay, as an output-disable, on reads.

Top module: `burst_col_gen`

## Requirements
- R1: With `burst_ilv_i` = 0 and a fixed length L (`burst_len_i` 0→1, 1→2, 2→4, 3→8; codes 4 to 6 act as 1), beat i addresses (start rounded down to a multiple of L) + ((start mod L + i) mod L). A length-4 burst from column 2 gives 2, 3, 0, 1.
- R2: With `burst_ilv_i` = 1 and a fixed length L, beat i addresses (start rounded down to a multiple of L) + ((start mod L) XOR i). A length-8 burst from column 3 gives 3, 2, 1, 0, 7, 6, 5, 4.
- R3: `burst_len_i` = 7 selects page mode. Beat i is (start + i) mod 1024 whatever the ordering input. The burst does not end by itself, and `col_last_o` never rises.
- R4: A high `burst_stop_i` at an edge with no start ends the burst at any length. `col_valid_o` is low in the cycle after that edge.
- R5: A start taken at an edge puts beat 0 on `col_o` in the next cycle, with one new beat per cycle after that. A start during a burst drops the rest of the old burst, and the new beat 0 follows the current old beat with no gap.
- R6: `col_last_o` is high on the final beat of a fixed-length burst and on no other beat. `col_valid_o` is low in the next cycle unless a new start was taken.
- R7: With `single_wr_i` = 1, a write burst has exactly one beat and that beat is marked last. A read burst keeps its programmed length.
- R8: During a write beat, `wr_mask_o` follows `dq_mask_i` in the same cycle. It is 0 during read beats and idle cycles.
- R9: `dq_mask_i` high in the cycle before edge e sets `rd_hiz_o` in the cycle after edge e+1, when a read-data beat falls in that cycle (two-cycle read mask latency).
- R10: `rd_valid_o` is high CL cycles after each read beat is on `col_o`, where CL is `cas_lat_i` (1, 2 or 3; 0 acts as 1). Write beats never raise it.
- R11: After reset, `col_valid_o`, `col_last_o`, `rd_valid_o` and `rd_hiz_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_start_i | input | 1 | Start a burst at this edge |
| cmd_write_i | input | 1 | 1 = write burst, 0 = read burst |
| cmd_col_i | input | 10 | Start column |
| burst_len_i | input | 3 | Length code (see R1, R3) |
| burst_ilv_i | input | 1 | 0 = wrapping order, 1 = XOR order |
| single_wr_i | input | 1 | Writes use one beat |
| burst_stop_i | input | 1 | End the running burst |
| cas_lat_i | input | 2 | Read latency in cycles (1 to 3) |
| dq_mask_i | input | 1 | Data mask |
| col_o | output | 10 | Column address of the current beat |
| col_valid_o | output | 1 | A beat is on `col_o` |
| col_last_o | output | 1 | Final beat of a fixed burst |
| col_write_o | output | 1 | Current beat belongs to a write |
| wr_mask_o | output | 1 | Write data of this cycle is masked |
| rd_valid_o | output | 1 | Read data belongs in this cycle |
| rd_hiz_o | output | 1 | Read data of this cycle is driven off |

## Verification
A corrupted beat counter or captured start column shows on `col_o` at the very next beat. It appears either as a wrong address or as a last flag on the wrong beat, and the beat-by-beat scoreboard catches it at once. A wrong run state, such as a burst that ignores a stop or ends too early, shows as a valid beat the scoreboard did not expect, or as a missing one, within one cycle of the edge that should have changed it. A fault in the latency or mask delay lines moves `rd_valid_o` or `rd_hiz_o` by whole cycles. The directed checks count the edges from the beat to the data slot, so they catch that shift.

// File: rtl/bcg_pkg.sv
// Shared types and decode for the burst column address generator.
// Assumes column widths below 16 bits, so the length exponent fits 4 bits.
package bcg_pkg;

    localparam int LG_W = 4;

    // Length codes taken on burst_len_i
    typedef enum logic [2:0] {
        BL_ONE   = 3'd0,
        BL_TWO   = 3'd1,
        BL_FOUR  = 3'd2,
        BL_EIGHT = 3'd3,
        BL_PAGE  = 3'd7
    } bl_code_e;

    // Captured span of a burst: page mode flag and log2 of the fixed length
    typedef struct packed {
        logic            full;
        logic [LG_W-1:0] lg;
    } span_t;

    // Turn a length code into a span; single-write cuts writes to one beat
    function automatic span_t decode_span(input logic [2:0] code,
                                          input logic wr,
                                          input logic sbw,
                                          input int unsigned col_w);
        span_t s;
        s.full = 1'b0;
        s.lg   = '0;
        case (code)
            BL_TWO:   s.lg = LG_W'(1);
            BL_FOUR:  s.lg = LG_W'(2);
            BL_EIGHT: s.lg = LG_W'(3);
            BL_PAGE: begin
                s.full = 1'b1;
                s.lg   = LG_W'(col_w);
            end
            default:  s.lg = '0;
        endcase
        if (wr && sbw) begin
            s.full = 1'b0;
            s.lg   = '0;
        end
        return s;
    endfunction

endpackage

// File: rtl/bcg_burst_ctrl.sv
// Burst run control: captures a command, steps the beat index once per
// cycle and ends the burst on its last beat or on a stop.
// Assumes a start outranks a stop at the same edge.
module bcg_burst_ctrl
    import bcg_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             write_i,
    input  logic [COL_W-1:0] col_i,
    input  logic [2:0]       len_code_i,
    input  logic             ilv_i,
    input  logic             sbw_i,
    output logic             active_o,
    output logic [COL_W-1:0] idx_o,
    output logic [COL_W-1:0] base_o,
    output span_t            span_o,
    output logic             ilv_o,
    output logic             write_o,
    output logic             last_o
);

    localparam logic [COL_W-1:0] ONE = COL_W'(1);

    logic             active_q;
    logic [COL_W-1:0] idx_q;
    logic [COL_W-1:0] base_q;
    span_t            span_q;
    logic             ilv_q;
    logic             wr_q;
    logic [COL_W-1:0] len_m1;

    // Index of the final beat for the captured fixed length
    always_comb len_m1 = (ONE << span_q.lg) - ONE;

    // Last beat: fixed length only, index at its end
    always_comb last_o = active_q && !span_q.full && (idx_q == len_m1);

    // Command capture, beat stepping and burst end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            idx_q    <= '0;
            base_q   <= '0;
            span_q   <= '0;
            ilv_q    <= 1'b0;
            wr_q     <= 1'b0;
        end else if (start_i) begin
            active_q <= 1'b1;
            idx_q    <= '0;
            base_q   <= col_i;
            span_q   <= decode_span(len_code_i, write_i, sbw_i, COL_W);
            ilv_q    <= ilv_i;
            wr_q     <= write_i;
        end else if (active_q) begin
            if (stop_i || last_o) begin
                active_q <= 1'b0;
            end else begin
                idx_q <= idx_q + ONE;
            end
        end
    end

    assign active_o = active_q;
    assign idx_o    = idx_q;
    assign base_o   = base_q;
    assign span_o   = span_q;
    assign ilv_o    = ilv_q;
    assign write_o  = wr_q;

    // Beats advance by exactly one per cycle while a burst runs
    assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && !start_i && !stop_i && !last_o) |=>
            (active_q && idx_q == $past(idx_q) + ONE));

    // A start opens a burst at beat 0 on the next cycle
    assert_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (active_q && idx_q == '0));

    // A stop without a start closes the burst
    assert_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !start_i) |=> !active_q);

    // A fixed burst ends right after its last beat
    assert_last_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && !start_i) |=> !active_q);

endmodule

// File: rtl/bcg_addr_map.sv
// Column address for a beat: wrapping order within an aligned block, XOR
// order within that block, or a page-wide wrap in page mode.
// Purely combinational; assumes idx_i stays below the burst length.
module bcg_addr_map
    import bcg_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] idx_i,
    input  span_t            span_i,
    input  logic             ilv_i,
    output logic [COL_W-1:0] col_o
);

    localparam logic [COL_W-1:0] ONE = COL_W'(1);

    logic [COL_W-1:0] blk_mask;
    logic [COL_W-1:0] wrap_col;
    logic [COL_W-1:0] xor_col;

    // Offset bits that move within the burst block
    always_comb blk_mask = span_i.full ? '1 : ((ONE << span_i.lg) - ONE);

    // Both orderings, then the pick
    always_comb begin
        wrap_col = (base_i & ~blk_mask) | ((base_i + idx_i) & blk_mask);
        xor_col  = base_i ^ (idx_i & blk_mask);
        col_o    = (ilv_i && !span_i.full) ? xor_col : wrap_col;
    end

endmodule

// File: rtl/bcg_lat_pipe.sv
// Read timing: delays a read-beat marker by the CAS latency and the data
// mask by the fixed read mask latency. Assumes the latency input is held
// steady while reads are in flight.
module bcg_lat_pipe #(
    parameter int MAX_CL      = 3,
    parameter int RD_MASK_LAT = 2,
    parameter int CL_W        = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd_beat_i,
    input  logic [CL_W-1:0] cas_lat_i,
    input  logic            mask_i,
    output logic            rd_valid_o,
    output logic            rd_hiz_o
);

    logic [MAX_CL-1:0]      rd_sh;
    logic [RD_MASK_LAT-1:0] mk_sh;
    logic [CL_W-1:0]        tap;

    // Latency to tap index, with 0 read as 1 and large values clamped
    always_comb begin
        if (cas_lat_i == '0)
            tap = '0;
        else if (int'(cas_lat_i) > MAX_CL)
            tap = CL_W'(MAX_CL - 1);
        else
            tap = cas_lat_i - CL_W'(1);
    end

    generate
        if (MAX_CL == 1) begin : g_rd_one
            // Single-stage read marker delay
            always_ff @(posedge clk) begin
                if (!rst_n) rd_sh <= '0;
                else        rd_sh <= rd_beat_i;
            end
        end else begin : g_rd_many
            // Multi-stage read marker delay line
            always_ff @(posedge clk) begin
                if (!rst_n) rd_sh <= '0;
                else        rd_sh <= {rd_sh[MAX_CL-2:0], rd_beat_i};
            end
        end

        if (RD_MASK_LAT == 1) begin : g_mk_one
            // Single-stage read mask delay
            always_ff @(posedge clk) begin
                if (!rst_n) mk_sh <= '0;
                else        mk_sh <= mask_i;
            end
        end else begin : g_mk_many
            // Multi-stage read mask delay line
            always_ff @(posedge clk) begin
                if (!rst_n) mk_sh <= '0;
                else        mk_sh <= {mk_sh[RD_MASK_LAT-2:0], mask_i};
            end
        end

        if (RD_MASK_LAT == 2) begin : g_mk_chk
            // Mask reaches the end of the delay line two edges later
            assert_rd_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
                mask_i |=> ##1 mk_sh[RD_MASK_LAT-1]);
        end
    endgenerate

    // Read data slot and its output disable
    always_comb begin
        rd_valid_o = rd_sh[tap];
        rd_hiz_o   = rd_valid_o && mk_sh[RD_MASK_LAT-1];
    end

    // With latency 1, a read beat yields a data slot on the next cycle
    assert_cl1_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_beat_i && cas_lat_i == CL_W'(1)) |=>
            (rd_valid_o || cas_lat_i != CL_W'(1)));

endmodule

// File: rtl/burst_col_gen.sv
// Burst column address generator top: run control, address mapping and
// read latency pipe. Write masking has zero latency and is combinational.
// Assumes length, ordering and latency settings are static during a burst.
module burst_col_gen
    import bcg_pkg::*;
#(
    parameter int COL_W       = 10,
    parameter int MAX_CL      = 3,
    parameter int RD_MASK_LAT = 2,
    parameter int CL_W        = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_start_i,
    input  logic             cmd_write_i,
    input  logic [COL_W-1:0] cmd_col_i,
    input  logic [2:0]       burst_len_i,
    input  logic             burst_ilv_i,
    input  logic             single_wr_i,
    input  logic             burst_stop_i,
    input  logic [CL_W-1:0]  cas_lat_i,
    input  logic             dq_mask_i,
    output logic [COL_W-1:0] col_o,
    output logic             col_valid_o,
    output logic             col_last_o,
    output logic             col_write_o,
    output logic             wr_mask_o,
    output logic             rd_valid_o,
    output logic             rd_hiz_o
);

    logic             active;
    logic [COL_W-1:0] idx;
    logic [COL_W-1:0] base;
    span_t            span;
    logic             ilv;
    logic             wr;
    logic             last;

    bcg_burst_ctrl #(.COL_W(COL_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (cmd_start_i),
        .stop_i     (burst_stop_i),
        .write_i    (cmd_write_i),
        .col_i      (cmd_col_i),
        .len_code_i (burst_len_i),
        .ilv_i      (burst_ilv_i),
        .sbw_i      (single_wr_i),
        .active_o   (active),
        .idx_o      (idx),
        .base_o     (base),
        .span_o     (span),
        .ilv_o      (ilv),
        .write_o    (wr),
        .last_o     (last)
    );

    bcg_addr_map #(.COL_W(COL_W)) u_map (
        .base_i (base),
        .idx_i  (idx),
        .span_i (span),
        .ilv_i  (ilv),
        .col_o  (col_o)
    );

    bcg_lat_pipe #(
        .MAX_CL      (MAX_CL),
        .RD_MASK_LAT (RD_MASK_LAT),
        .CL_W        (CL_W)
    ) u_pipe (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_beat_i  (active && !wr),
        .cas_lat_i  (cas_lat_i),
        .mask_i     (dq_mask_i),
        .rd_valid_o (rd_valid_o),
        .rd_hiz_o   (rd_hiz_o)
    );

    // Beat flags and same-cycle write masking
    always_comb begin
        col_valid_o = active;
        col_last_o  = last;
        col_write_o = active && wr;
        wr_mask_o   = dq_mask_i && active && wr;
    end

endmodule

// File: tb/burst_col_gen_tb.sv
// Scoreboard bench: drivers queue expected beats, a monitor pops them.
module burst_col_gen_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_start_i = 1'b0;
    logic       cmd_write_i = 1'b0;
    logic [9:0] cmd_col_i = '0;
    logic [2:0] burst_len_i = '0;
    logic       burst_ilv_i = 1'b0;
    logic       single_wr_i = 1'b0;
    logic       burst_stop_i = 1'b0;
    logic [1:0] cas_lat_i = 2'd2;
    logic       dq_mask_i = 1'b0;
    logic [9:0] col_o;
    logic       col_valid_o, col_last_o, col_write_o;
    logic       wr_mask_o, rd_valid_o, rd_hiz_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int exp_col[$];
    bit exp_last[$];

    burst_col_gen u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_start_i(cmd_start_i),
        .cmd_write_i(cmd_write_i), .cmd_col_i(cmd_col_i),
        .burst_len_i(burst_len_i), .burst_ilv_i(burst_ilv_i),
        .single_wr_i(single_wr_i), .burst_stop_i(burst_stop_i),
        .cas_lat_i(cas_lat_i), .dq_mask_i(dq_mask_i), .col_o(col_o),
        .col_valid_o(col_valid_o), .col_last_o(col_last_o),
        .col_write_o(col_write_o), .wr_mask_o(wr_mask_o),
        .rd_valid_o(rd_valid_o), .rd_hiz_o(rd_hiz_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int len_of(input int code);
        case (code)
            1: return 2;
            2: return 4;
            3: return 8;
            default: return 1;
        endcase
    endfunction

    // Expected address of beat i, from the requirement formulas
    function automatic int ref_col(input int col, input int len, input bit ilv,
                                   input bit page, input int i);
        int off, blk;
        if (page) return (col + i) % 1024;
        off = col % len;
        blk = col - off;
        if (ilv) return blk + (off ^ i);
        return blk + ((off + i) % len);
    endfunction

    task automatic push(input int col, input int len, input bit ilv,
                        input bit page, input int first, input int n, input bit mark_last);
        for (int i = first; i < first + n; i++) begin
            exp_col.push_back(ref_col(col, len, ilv, page, i));
            exp_last.push_back(mark_last && (i == len - 1));
        end
    endtask

    // Drive a start for one edge; returns at the cycle showing beat 0
    task automatic issue(input int col, input int code, input bit ilv, input bit wr);
        cmd_col_i   = 10'(col);
        burst_len_i = 3'(code);
        burst_ilv_i = ilv;
        cmd_write_i = wr;
        cmd_start_i = 1'b1;
        @(negedge clk);
        cmd_start_i = 1'b0;
    endtask

    // Full fixed burst, then check the burst has ended
    task automatic run_fixed(input int col, input int code, input bit ilv,
                             input bit wr, input string req);
        int len;
        len = (wr && single_wr_i) ? 1 : len_of(code);
        push(col, len, ilv, 1'b0, 0, len, 1'b1);
        issue(col, code, ilv, wr);
        repeat (len) @(negedge clk);
        check(col_valid_o == 1'b0, req, col_valid_o, 0);
        repeat (2) @(negedge clk);
    endtask

    // Monitor: pops one expected beat per valid cycle (R1 R2 R3 R6)
    always @(negedge clk) begin
        if (rst_n && col_valid_o) begin
            if (exp_col.size() == 0) begin
                check(1'b0, "R5 unexpected beat", col_o, -1);
            end else begin
                int ec;
                bit el;
                ec = exp_col.pop_front();
                el = exp_last.pop_front();
                check(col_o == 10'(ec), "R1/R2/R3 column", col_o, ec);
                check(col_last_o == el, "R6 last flag", col_last_o, el);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            check(1'b0, "watchdog", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11: reset state
        check(col_valid_o == 0 && col_last_o == 0, "R11 beat flags", col_valid_o, 0);
        check(rd_valid_o == 0 && rd_hiz_o == 0, "R11 read flags", rd_valid_o, 0);

        // R1: wrapping order, several lengths and starts
        run_fixed(2, 2, 0, 0, "R1 len4 end");
        run_fixed(5, 3, 0, 0, "R1 len8 end");
        run_fixed(1, 1, 0, 1, "R1 len2 end");
        run_fixed(9, 0, 0, 0, "R1 len1 end");
        // R2: XOR order
        run_fixed(3, 3, 1, 0, "R2 len8 end");
        run_fixed(6, 2, 1, 1, "R2 len4 end");

        // R3: page mode wraps past 1023 and runs on; R4 stop ends it
        push(1022, 1024, 0, 1'b1, 0, 1030, 1'b0);
        issue(1022, 7, 1, 0);
        repeat (1029) @(negedge clk);
        check(col_valid_o == 1, "R3 page still running", col_valid_o, 1);
        burst_stop_i = 1'b1;
        @(negedge clk);
        burst_stop_i = 1'b0;
        check(col_valid_o == 0, "R4 page stop", col_valid_o, 0);
        repeat (2) @(negedge clk);

        // R4: stop a length-8 burst after 3 beats
        push(16, 8, 0, 1'b0, 0, 3, 1'b1);
        issue(16, 3, 0, 0);
        repeat (2) @(negedge clk);
        burst_stop_i = 1'b1;
        @(negedge clk);
        burst_stop_i = 1'b0;
        check(col_valid_o == 0, "R4 fixed stop", col_valid_o, 0);
        repeat (2) @(negedge clk);

        // R5: new start during beat 1 of a length-8 burst
        push(40, 8, 0, 1'b0, 0, 2, 1'b1);
        push(13, 4, 1, 1'b0, 0, 4, 1'b1);
        issue(40, 3, 0, 0);
        @(negedge clk);
        issue(13, 2, 1, 0);
        check(col_valid_o == 1 && col_o == 10'd13, "R5 preempt beat0", col_o, 13);
        repeat (4) @(negedge clk);
        check(col_valid_o == 0, "R5 preempt end", col_valid_o, 0);
        repeat (2) @(negedge clk);

        // R7: single-write: write one beat, read keeps length
        single_wr_i = 1'b1;
        run_fixed(7, 3, 0, 1, "R7 write one beat");
        run_fixed(7, 2, 0, 0, "R7 read keeps length");
        single_wr_i = 1'b0;

        // R8: write mask same cycle, not on reads
        push(20, 2, 0, 1'b0, 0, 2, 1'b1);
        issue(20, 1, 0, 1);
        dq_mask_i = 1'b1;
        #1 check(wr_mask_o == 1, "R8 write masked", wr_mask_o, 1);
        @(negedge clk);
        dq_mask_i = 1'b0;
        #1 check(wr_mask_o == 0, "R8 write unmasked", wr_mask_o, 0);
        repeat (3) @(negedge clk);
        push(24, 2, 0, 1'b0, 0, 2, 1'b1);
        issue(24, 1, 0, 0);
        dq_mask_i = 1'b1;
        #1 check(wr_mask_o == 0, "R8 read not write-masked", wr_mask_o, 0);
        @(negedge clk);
        dq_mask_i = 1'b0;
        repeat (6) @(negedge clk);

        // R9: read mask two cycles later, CL 2
        cas_lat_i = 2'd2;
        push(0, 4, 0, 1'b0, 0, 4, 1'b1);
        issue(0, 2, 0, 0);
        @(negedge clk);
        dq_mask_i = 1'b1;
        @(negedge clk);
        dq_mask_i = 1'b0;
        check(rd_valid_o == 1 && rd_hiz_o == 0, "R9 beat0 driven", rd_hiz_o, 0);
        @(negedge clk);
        check(rd_valid_o == 1 && rd_hiz_o == 1, "R9 beat1 off", rd_hiz_o, 1);
        @(negedge clk);
        check(rd_valid_o == 1 && rd_hiz_o == 0, "R9 beat2 driven", rd_hiz_o, 0);
        repeat (6) @(negedge clk);

        // R10: read data slot at CL 1, 2, 3; none for writes
        for (int cl = 1; cl <= 3; cl++) begin
            cas_lat_i = 2'(cl);
            push(5, 1, 0, 1'b0, 0, 1, 1'b1);
            issue(5, 0, 0, 0);
            n = 0;
            while (!rd_valid_o && n < 6) begin
                @(negedge clk);
                n++;
            end
            check(n == cl, "R10 read latency", n, cl);
            repeat (5) @(negedge clk);
        end
        push(8, 4, 0, 1'b0, 0, 4, 1'b1);
        issue(8, 2, 0, 1);
        n = 0;
        for (int i = 0; i < 8; i++) begin
            if (rd_valid_o) n++;
            @(negedge clk);
        end
        check(n == 0, "R10 write no data slot", n, 0);

        check(exp_col.size() == 0, "R5 beats missing", exp_col.size(), 0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule